// File: doc/BRIEF.md
# Serial Channel Interrupt Priority Controller

This block arbitrates the interrupt requests of one channel of a synchronous serial controller. It has four sources: receive special condition, receive character available, transmit, and external/status. Each source has a pending flag (IP) and an under-service flag (IUS). The block drives an active-low interrupt request and the enable that feeds the next device in a daisy chain. It also owns the receive data FIFO lock that the special-condition path asserts.

Receive data is often drained by DMA while the frame-status FIFO is running and receive interrupts are set to special conditions only. In that mode an end-of-frame byte raises a character-available interrupt rather than a special-condition one, and it leaves the data FIFO unlocked so that bytes of the next frame keep flowing in. Parity, overrun and CRC errors still lock the FIFO. The reset-highest-IUS command retires exactly one service level and never touches a pending flag. A low-priority handler that issues this command therefore cannot lose a pending end-of-frame.

Top module: `irq_chain_ctl`

## Requirements
- R1: After reset, ip and ius read 0000, fifo_lock is 0, int_n is 1, and ieo follows iei.
- R2: Bit positions in ip and ius are: bit 0 special condition, bit 1 character available, bit 2 transmit, bit 3 external/status. Priority falls from bit 0 to bit 3. tx_stb sets bit 2 only while tx_ie is 1, and ext_stb sets bit 3 only while ext_ie is 1. A strobe whose enable is 0 leaves ip unchanged.
- R3: rxi_mode encodes 00 receive interrupts off, 01 or 11 every character, and 10 special conditions only. rx_char_stb sets ip bit 1 only in modes 01 and 11. In mode 00, no receive strobe changes ip or fifo_lock.
- R4: rx_err_stb, in any mode other than 00, sets ip bit 0 and sets fifo_lock in the following cycle.
- R5: When stat_fifo_en is 1 and rxi_mode is 10, rx_eof_stb sets ip bit 1 and neither sets ip bit 0 nor touches fifo_lock.
- R6: In every other mode except 00, rx_eof_stb sets ip bit 0 and sets fifo_lock.
- R7: int_n is 0 exactly when mie and iei are both 1 and some ip bit is set while neither that bit nor any higher-priority bit in ius is set.
- R8: An intack cycle with int_n low sets the ius bit of the highest-priority requesting source and clears its ip bit on the next edge. While int_n is high, intack has no effect.
- R9: rst_ius_cmd clears only the highest-priority ius bit that is set. It never changes ip, even when an end-of-frame flag on bit 1 is pending below an external/status routine that is under service.
- R10: ieo is 1 only when iei is 1, ius is zero, and ip is zero or mie is 0.
- R11: unlock_cmd clears fifo_lock. A lock-setting event in the same cycle wins over the unlock.
- R12: When a source is acknowledged in the same cycle that it receives a new event, its ip bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_char_stb | input | 1 | A received byte was taken from the data FIFO |
| rx_eof_stb | input | 1 | The byte taken carries the end-of-frame mark |
| rx_err_stb | input | 1 | Parity, overrun or CRC error on the byte taken |
| tx_stb | input | 1 | Transmit buffer empty event |
| ext_stb | input | 1 | External/status event |
| stat_fifo_en | input | 1 | Frame-status FIFO enabled |
| rxi_mode | input | 2 | Receive interrupt mode (see R3) |
| tx_ie | input | 1 | Transmit interrupt enable |
| ext_ie | input | 1 | External/status interrupt enable |
| mie | input | 1 | Master interrupt enable |
| iei | input | 1 | Daisy-chain enable from the higher device |
| intack | input | 1 | Interrupt acknowledge strobe |
| rst_ius_cmd | input | 1 | Reset-highest-IUS command strobe |
| unlock_cmd | input | 1 | Special-condition FIFO unlock command strobe |
| int_n | output | 1 | Active-low interrupt request |
| ieo | output | 1 | Daisy-chain enable to the lower device |
| fifo_lock | output | 1 | Receive data FIFO lock |
| ip | output | 4 | Pending flags (see R2) |
| ius | output | 4 | Under-service flags (see R2) |

## Verification
The bench drives the failure sequence head-on. The external/status source is acknowledged and put under service, an end-of-frame in anti-lock mode then raises bit 1, and the handler issues reset-highest-IUS. A controller that cleared the highest set flag across ip and ius together would drop the frame-end interrupt and let int_n go high. Further cases cover end-of-frame in the anti-lock mode and in the locking modes, an unlock in the same cycle as an error, an acknowledge in the same cycle as a new event on the granted source, nested service levels, and a low iei. Each of these targets one fault: a design that locked on every end-of-frame, let unlock win, lost the fresh event, cleared the wrong service level, or ignored the chain would each diverge from the reference model within a cycle. A long stretch of random stimulus then exercises the mode and enable combinations against the same model.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
   localparam int SRC_N   = 4;
   localparam int SRC_SPC = 0;
   localparam int SRC_RCA = 1;
   localparam int SRC_TX  = 2;
   localparam int SRC_EXT = 3;

   typedef logic [SRC_N-1:0] src_vec_t;

   typedef enum logic [1:0] {
      RXI_OFF  = 2'b00,
      RXI_ALL  = 2'b01,
      RXI_SPEC = 2'b10,
      RXI_ALLX = 2'b11
   } rxi_mode_e;
endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
   parameter int WIDTH  = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] vec,
   output logic [WIDTH-1:0] first,
   output logic             any
);
   initial assert (WIDTH >= 2) else $fatal(1, "irq_first_set: WIDTH must be at least 2");

   generate
      if (RIPPLE) begin : g_mask
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            localparam logic [WIDTH-1:0] BELOW = (WIDTH'(1) << i) - WIDTH'(1);
            assign first[i] = vec[i] & ~|(vec & BELOW);
         end
      end else begin : g_arith
         assign first = vec & (~vec + WIDTH'(1));
      end
   endgenerate

   assign any = |vec;
endmodule

// File: rtl/irq_rx_route.sv
module irq_rx_route
   import irq_chain_pkg::*;
#(
   parameter bit ANTILOCK_EN = 1'b1
) (
   input  logic      char_stb,
   input  logic      eof_stb,
   input  logic      err_stb,
   input  logic      stat_fifo_en,
   input  rxi_mode_e mode,
   output logic      set_spc,
   output logic      set_rca,
   output logic      lock_set
);
   logic rx_on, every_char, antilock;

   always_comb begin
      rx_on      = (mode != RXI_OFF);
      every_char = (mode == RXI_ALL) || (mode == RXI_ALLX);
      antilock   = ANTILOCK_EN && stat_fifo_en && (mode == RXI_SPEC);
      set_rca    = (rx_on & every_char & char_stb) | (antilock & eof_stb);
      set_spc    = rx_on & (err_stb | (eof_stb & ~antilock));
      lock_set   = set_spc;
   end
endmodule

// File: rtl/irq_chain_ctl.sv
module irq_chain_ctl
   import irq_chain_pkg::*;
#(
   parameter bit PICK_RIPPLE = 1'b1,
   parameter bit ANTILOCK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_char_stb,
   input  logic             rx_eof_stb,
   input  logic             rx_err_stb,
   input  logic             tx_stb,
   input  logic             ext_stb,
   input  logic             stat_fifo_en,
   input  logic [1:0]       rxi_mode,
   input  logic             tx_ie,
   input  logic             ext_ie,
   input  logic             mie,
   input  logic             iei,
   input  logic             intack,
   input  logic             rst_ius_cmd,
   input  logic             unlock_cmd,
   output logic             int_n,
   output logic             ieo,
   output logic             fifo_lock,
   output logic [SRC_N-1:0] ip,
   output logic [SRC_N-1:0] ius
);
   src_vec_t  ip_q, ius_q, set_vec, blk, req, grant, ius_hi, ack_set, ius_clr;
   logic      req_any, ius_any, ack_ok, lock_q;
   logic      set_spc, set_rca, lock_set;
   rxi_mode_e mode;

   assign mode = rxi_mode_e'(rxi_mode);

   irq_rx_route #(.ANTILOCK_EN(ANTILOCK_EN)) u_route (
      .char_stb(rx_char_stb), .eof_stb(rx_eof_stb), .err_stb(rx_err_stb),
      .stat_fifo_en(stat_fifo_en), .mode(mode),
      .set_spc(set_spc), .set_rca(set_rca), .lock_set(lock_set)
   );

   // a source is blocked by its own or any higher service level
   generate
      for (genvar i = 0; i < SRC_N; i++) begin : g_blk
         localparam src_vec_t UPTO = {SRC_N{1'b1}} >> (SRC_N - 1 - i);
         assign blk[i] = |(ius_q & UPTO);
      end
   endgenerate

   assign req = ip_q & ~blk;

   irq_first_set #(.WIDTH(SRC_N), .RIPPLE(PICK_RIPPLE)) u_pick_req (
      .vec(req), .first(grant), .any(req_any)
   );
   irq_first_set #(.WIDTH(SRC_N), .RIPPLE(PICK_RIPPLE)) u_pick_ius (
      .vec(ius_q), .first(ius_hi), .any(ius_any)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[SRC_SPC] = set_spc;
      set_vec[SRC_RCA] = set_rca;
      set_vec[SRC_TX]  = tx_stb & tx_ie;
      set_vec[SRC_EXT] = ext_stb & ext_ie;
      ack_ok           = intack & iei & mie & req_any;
      ack_set          = ack_ok ? grant : '0;
      ius_clr          = rst_ius_cmd ? ius_hi : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ip_q   <= '0;
         ius_q  <= '0;
         lock_q <= 1'b0;
      end else begin
         ip_q   <= (ip_q & ~ack_set) | set_vec;
         ius_q  <= (ius_q & ~ius_clr) | ack_set;
         lock_q <= lock_set | (lock_q & ~unlock_cmd);
      end
   end

   assign int_n     = ~(mie & iei & req_any);
   assign ieo       = iei & ~ius_any & ~(mie & |ip_q);
   assign fifo_lock = lock_q;
   assign ip        = ip_q;
   assign ius       = ius_q;

   assert_rx_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == RXI_OFF && !ip_q[SRC_SPC] && !lock_q && !unlock_cmd) |=> (!ip_q[SRC_SPC] && !lock_q));

   assert_err_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_err_stb && mode != RXI_OFF) |=> (lock_q && ip_q[SRC_SPC]));

   assert_antilock_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ANTILOCK_EN && stat_fifo_en && mode == RXI_SPEC && rx_eof_stb && !rx_err_stb && !lock_q)
      |=> (!lock_q && ip_q[SRC_RCA]));

   assert_int_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mie && iei) |-> int_n);

   assert_ack_grants_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_ok |=> ((ius_q & $past(grant)) != '0));

   assert_rsthi_keeps_ip_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_ius_cmd && !ack_ok && set_vec == '0) |=> (ip_q == $past(ip_q)));

   assert_rsthi_one_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_ius_cmd && !ack_ok && ius_any) |=> ($countones(ius_q) == $countones($past(ius_q)) - 1));

   assert_ieo_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ius_any |-> !ieo);
endmodule

// File: tb/sim_irq_chain_ctl.sv
module sim_irq_chain_ctl;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, rx_char_stb, rx_eof_stb, rx_err_stb, tx_stb, ext_stb, stat_fifo_en;
   logic [1:0] rxi_mode;
   logic tx_ie, ext_ie, mie, iei, intack, rst_ius_cmd, unlock_cmd;
   logic int_n, ieo, fifo_lock;
   logic [3:0] ip, ius;

   irq_chain_ctl u0 (
      .clk(clk), .rst_n(rst_n), .rx_char_stb(rx_char_stb), .rx_eof_stb(rx_eof_stb),
      .rx_err_stb(rx_err_stb), .tx_stb(tx_stb), .ext_stb(ext_stb), .stat_fifo_en(stat_fifo_en),
      .rxi_mode(rxi_mode), .tx_ie(tx_ie), .ext_ie(ext_ie), .mie(mie), .iei(iei),
      .intack(intack), .rst_ius_cmd(rst_ius_cmd), .unlock_cmd(unlock_cmd),
      .int_n(int_n), .ieo(ieo), .fifo_lock(fifo_lock), .ip(ip), .ius(ius)
   );

   int checks = 0;
   int fails  = 0;
   string tag = "R1";

   bit [3:0] m_ip, m_ius;
   bit       m_lock;

   function automatic bit [3:0] m_req();
      bit [3:0] r = '0;
      for (int i = 0; i < 4; i++) begin
         bit busy = 1'b0;
         for (int j = 0; j <= i; j++) if (m_ius[j]) busy = 1'b1;
         r[i] = m_ip[i] && !busy;
      end
      return r;
   endfunction

   function automatic bit [3:0] lowest(bit [3:0] v);
      for (int i = 0; i < 4; i++) if (v[i]) return 4'(1 << i);
      return 4'b0000;
   endfunction

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit e_int_n = !(mie && iei && m_req() != 0);
      bit e_ieo   = iei && m_ius == 0 && !(mie && m_ip != 0);
      chk("ip", int'(ip), int'(m_ip));
      chk("ius", int'(ius), int'(m_ius));
      chk("fifo_lock", int'(fifo_lock), int'(m_lock));
      chk("int_n", int'(int_n), int'(e_int_n));
      chk("ieo", int'(ieo), int'(e_ieo));
   endtask

   task automatic tick();
      bit [3:0] req = m_req();
      bit       ack = intack && iei && mie && req != 0;
      bit [3:0] ackv = ack ? lowest(req) : 4'b0000;
      bit [3:0] hiv  = rst_ius_cmd ? lowest(m_ius) : 4'b0000;
      bit rx_on = rxi_mode != 2'b00;
      bit every = rxi_mode == 2'b01 || rxi_mode == 2'b11;
      bit anti  = stat_fifo_en && rxi_mode == 2'b10;
      bit [3:0] setv;
      bit [3:0] n_ip, n_ius;
      bit       n_lock;
      setv[0] = rx_on && (rx_err_stb || (rx_eof_stb && !anti));
      setv[1] = (rx_on && every && rx_char_stb) || (anti && rx_eof_stb);
      setv[2] = tx_stb && tx_ie;
      setv[3] = ext_stb && ext_ie;
      n_ip   = (m_ip & ~ackv) | setv;
      n_ius  = (m_ius & ~hiv) | ackv;
      n_lock = setv[0] || (m_lock && !unlock_cmd);
      @(posedge clk);
      #1;
      m_ip = n_ip; m_ius = n_ius; m_lock = n_lock;
      rx_char_stb = 0; rx_eof_stb = 0; rx_err_stb = 0; tx_stb = 0; ext_stb = 0;
      intack = 0; rst_ius_cmd = 0; unlock_cmd = 0;
      compare();
   endtask

   task automatic drain();
      mie = 1; iei = 1;
      repeat (10) begin intack = 1; rst_ius_cmd = 1; unlock_cmd = 1; tick(); end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      rst_n = 0; rx_char_stb = 0; rx_eof_stb = 0; rx_err_stb = 0; tx_stb = 0; ext_stb = 0;
      stat_fifo_en = 0; rxi_mode = 2'b00; tx_ie = 0; ext_ie = 0; mie = 1; iei = 1;
      intack = 0; rst_ius_cmd = 0; unlock_cmd = 0;
      m_ip = 0; m_ius = 0; m_lock = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tag = "R1"; compare();

      // R2: disabled strobes ignored, enabled ones set
      tag = "R2"; tx_stb = 1; ext_stb = 1; tick();
      tx_ie = 1; ext_ie = 1; ext_stb = 1; tick();
      tx_stb = 1; tick();
      // R8: transmit outranks external/status
      tag = "R8"; intack = 1; tick();
      tag = "R7"; tick();
      // R9: retire transmit level, external still pending
      tag = "R9"; rst_ius_cmd = 1; tick();
      tag = "R8"; intack = 1; tick();
      tag = "R9"; rst_ius_cmd = 1; tick();

      // R3: receive modes
      tag = "R3"; rxi_mode = 2'b00; rx_char_stb = 1; rx_err_stb = 1; rx_eof_stb = 1; tick();
      rxi_mode = 2'b10; rx_char_stb = 1; tick();
      rxi_mode = 2'b01; rx_char_stb = 1; tick();
      drain();

      // R4: errors lock
      tag = "R4"; rxi_mode = 2'b10; stat_fifo_en = 1; rx_err_stb = 1; tick();
      tag = "R11"; unlock_cmd = 1; tick();
      drain();

      // R5: anti-lock end-of-frame
      tag = "R5"; rxi_mode = 2'b10; stat_fifo_en = 1; rx_eof_stb = 1; tick();
      tick();
      drain();

      // R6: locking end-of-frame modes
      tag = "R6"; stat_fifo_en = 0; rx_eof_stb = 1; tick();
      drain();
      stat_fifo_en = 1; rxi_mode = 2'b01; rx_eof_stb = 1; tick();
      drain();

      // R9: end-of-frame pending below an external routine in service
      tag = "R9"; rxi_mode = 2'b10; stat_fifo_en = 1; ext_stb = 1; tick();
      intack = 1; tick();
      rx_eof_stb = 1; tick();
      rst_ius_cmd = 1; tick();
      tag = "R7"; tick();
      drain();

      // R12: ack and fresh event on same source
      tag = "R12"; tx_stb = 1; tick();
      intack = 1; tx_stb = 1; tick();
      drain();

      // R11: lock event beats unlock
      tag = "R11"; rx_err_stb = 1; tick();
      rx_err_stb = 1; unlock_cmd = 1; tick();
      unlock_cmd = 1; tick();
      drain();

      // R10: chain input low blocks everything
      tag = "R10"; iei = 0; ext_stb = 1; tick();
      intack = 1; tick();
      iei = 1; tick();
      mie = 0; tick();
      mie = 1; tick();
      drain();

      // nested levels: external in service, then special condition nests
      tag = "R9"; ext_stb = 1; tick();
      intack = 1; tick();
      rx_err_stb = 1; tick();
      intack = 1; tick();
      rst_ius_cmd = 1; tick();
      rst_ius_cmd = 1; tick();
      drain();

      // random sweep against the model (R2, R3, R7, R8)
      tag = "R8";
      for (int n = 0; n < 2000; n++) begin
         bit [15:0] r = 16'($urandom);
         rx_char_stb  = r[0]; rx_eof_stb = r[1] & r[2]; rx_err_stb = r[3] & r[4] & r[5];
         tx_stb       = r[6]; ext_stb = r[7] & r[8];
         intack       = r[9]; rst_ius_cmd = r[10]; unlock_cmd = r[11] & r[12];
         if (n % 64 == 0) begin
            rxi_mode = 2'($urandom); stat_fifo_en = 1'($urandom);
            tx_ie = 1'($urandom); ext_ie = 1'($urandom);
         end
         mie = (r[13] | r[14]); iei = (r[15] | r[13] | r[14]);
         tick();
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule